// File: doc/BRIEF.md
# Serial Input Shift Register for a DAC Word

This block is the serial loading path of a DAC. While the serial-mode control is low, three of the data pins change role. One becomes the serial data input. One picks the bit order. One picks the word length. Each rising edge of the chip-select strobe moves one bit into the first-rank register, and that register itself does the shifting. The bit that is next to leave the register is always driven on a serial output pin. This lets several converters be chained: repeated strobes push the older data into the next device.

The chip-select strobe and the serial data come from outside the clock domain. Both pass through the same synchroniser so that they stay aligned. A rising edge is detected on the synchronised strobe, and the data bit is taken in the cycle that detects that edge. The path has no valid/ready handshake, because the strobe is the only flow control. Every detected edge is accepted and there is no back-pressure. The sender must therefore space its strobes at least a few system clocks apart. The full first-rank word is brought out so that a second-rank stage, which is outside this block, can load it on its own command.

Top module: `ser_dac_shreg`

## Requirements
- R1: After reset the first-rank word is all zeros and the serial output is 0.
- R2: Each rising edge of the strobe shifts the register by exactly one position. A strobe held high or a falling edge causes no further shift.
- R3: The word changes on the third rising clock edge after the strobe input goes high, counting two synchroniser stages and one edge-detect stage. Before that edge it is unchanged.
- R4: With order pin = 1 (MSB first) and length pin = 1 (18-bit), bits enter at bit 0 and move toward bit 17. After 18 strobes the word equals the 18 bits, with the first bit sent at bit 17.
- R5: With order pin = 0 (LSB first) and length pin = 1, bits enter at bit 17 and move toward bit 0. After 18 strobes the first bit sent sits at bit 0.
- R6: With length pin = 0 (16-bit), only bits 15..0 shift. The bit order follows the order pin, with MSB-first entry at bit 0 and LSB-first entry at bit 15. Bits 17..16 become 0 on every shift.
- R7: The serial output presents the bit that the next shift pushes out. For MSB first this is bit 17 (18-bit) or bit 15 (16-bit). For LSB first it is bit 0.
- R8: While the serial-mode control is high, strobes do not change the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_mode_n | input | 1 | Low enables serial loading |
| dat0_sin | input | 1 | Serial data input |
| dat1_order | input | 1 | Bit order: 1 = MSB first, 0 = LSB first |
| dat2_len | input | 1 | Word length: 1 = 18-bit, 0 = 16-bit |
| cs_strobe | input | 1 | Chip-select strobe; its rising edge shifts one bit |
| sout | output | 1 | Bit next to leave the register, for daisy chaining |
| rank1_word | output | 18 | First-rank register contents |

## Verification
On every cycle the checker confirms several behaviours. The word holds unless a shift is granted, and the shift grant lasts a single cycle. Each 18-bit shift moves the contents by one position in the selected direction. The upper two bits clear on a 16-bit shift, and the word is frozen while serial mode is off. Other behaviours can only be shown by the bench's scenarios. These are the end value of a whole word under each order and length, the exact arrival cycle after the synchroniser, and the bit presented for the next device in a chain.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;
  localparam int FULL_W  = 18;
  localparam int SHORT_W = 16;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    ORDER_LSB = 1'b0,
    ORDER_MSB = 1'b1
  } order_e;
endpackage

// File: rtl/dac_sync_chain.sv
module dac_sync_chain #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dac_shift_core.sv
module dac_shift_core
  import dac_ser_pkg::*;
#(
  parameter int FW = FULL_W,
  parameter int SW = SHORT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          sin,
  input  order_e        order,
  input  logic          long_word,
  output logic [FW-1:0] word_q,
  output logic          sout
);
  logic [FW-1:0] word_nxt;

  always_comb begin
    word_nxt = '0;
    if (order == ORDER_MSB) begin
      if (long_word) word_nxt = {word_q[FW-2:0], sin};
      else           word_nxt[SW-1:0] = {word_q[SW-2:0], sin};
    end else begin
      if (long_word) word_nxt = {sin, word_q[FW-1:1]};
      else           word_nxt[SW-1:0] = {sin, word_q[SW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (shift_en) word_q <= word_nxt;
  end

  always_comb begin
    if (order == ORDER_LSB) sout = word_q[0];
    else if (long_word)     sout = word_q[FW-1];
    else                    sout = word_q[SW-1];
  end
endmodule

// File: rtl/ser_dac_shreg.sv
module ser_dac_shreg
  import dac_ser_pkg::*;
#(
  parameter int FW     = FULL_W,
  parameter int SW     = SHORT_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_mode_n,
  input  logic          dat0_sin,
  input  logic          dat1_order,
  input  logic          dat2_len,
  input  logic          cs_strobe,
  output logic          sout,
  output logic [FW-1:0] rank1_word
);
  logic [1:0] sync_q;
  logic       cs_prev_q;
  logic       shift_en;
  order_e     order;

  dac_sync_chain #(.W(2), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_strobe, dat0_sin}),
    .q     (sync_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_prev_q <= 1'b0;
    else        cs_prev_q <= sync_q[1];
  end

  assign shift_en = sync_q[1] & ~cs_prev_q & ~ser_mode_n;
  assign order    = order_e'(dat1_order);

  dac_shift_core #(.FW(FW), .SW(SW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .sin       (sync_q[0]),
    .order     (order),
    .long_word (dat2_len),
    .word_q    (rank1_word),
    .sout      (sout)
  );
endmodule

// File: rtl/ser_dac_shreg_chk.sv
module ser_dac_shreg_chk #(
  parameter int FW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_mode_n,
  input logic          msb_first,
  input logic          long_word,
  input logic          shift_en,
  input logic [FW-1:0] word
);
  // R2: word moves only on a granted shift
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word));

  // R2: one grant per strobe edge
  p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !shift_en);

  p_msb_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && msb_first && long_word) |=> word[FW-1:1] == $past(word[FW-2:0]));

  p_lsb_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !msb_first && long_word) |=> word[FW-2:0] == $past(word[FW-1:1]));

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !long_word) |=> word[FW-1:FW-2] == 2'b00);

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_mode_n |=> $stable(word));
endmodule

bind ser_dac_shreg ser_dac_shreg_chk #(.FW(FW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ser_mode_n (ser_mode_n),
  .msb_first  (dat1_order),
  .long_word  (dat2_len),
  .shift_en   (shift_en),
  .word       (rank1_word)
);

// File: tb/test_ser_dac_shreg.sv
module test_ser_dac_shreg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_mode_n = 1'b0;
  logic sin = 1'b0, order = 1'b1, len = 1'b1, cs = 1'b0;
  logic sout;
  logic [17:0] word;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ser_dac_shreg i_ser_dac_shreg (
    .clk(clk), .rst_n(rst_n), .ser_mode_n(ser_mode_n), .dat0_sin(sin),
    .dat1_order(order), .dat2_len(len), .cs_strobe(cs),
    .sout(sout), .rank1_word(word)
  );

  // {order, len, data}
  localparam logic [19:0] VEC [4] = '{
    {1'b1, 1'b1, 18'h2A5C3},
    {1'b0, 1'b1, 18'h1F00F},
    {1'b1, 1'b0, 18'h0BEEF},
    {1'b0, 1'b0, 18'h01234}
  };

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic b);
    @(negedge clk); sin = b; cs = 1'b1;
    repeat (4) @(negedge clk);
    cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] snap;
    repeat (3) @(negedge clk);
    check("R1 word", word, 18'h0);
    check("R1 sout", {17'h0, sout}, 18'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R4, R5, R6, R7
    for (int v = 0; v < 4; v++) begin
      logic [17:0] d;
      int n;
      order = VEC[v][19];
      len   = VEC[v][18];
      d     = VEC[v][17:0];
      n     = len ? 18 : 16;
      for (int k = 0; k < n; k++)
        strobe(order ? d[n-1-k] : d[k]);
      check(order ? (len ? "R4 word" : "R6 msb word") : (len ? "R5 word" : "R6 lsb word"), word, d);
      check("R7 sout", {17'h0, sout}, {17'h0, order ? d[n-1] : d[0]});
    end

    // R7 daisy chain: MSB first 18-bit
    order = 1'b1; len = 1'b1;
    for (int k = 0; k < 18; k++) strobe(VEC[0][17-k]);
    strobe(1'b0);
    check("R7 chain word", word, {VEC[0][16:0], 1'b0});
    check("R7 chain sout", {17'h0, sout}, {17'h0, VEC[0][16]});

    // R3 latency
    snap = word;
    @(negedge clk); sin = 1'b1; cs = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R3 before third edge", word, snap);
    @(negedge clk);
    check("R3 at third edge", word, {snap[16:0], 1'b1});
    // R2 held high: no further shift
    snap = word;
    repeat (10) @(negedge clk);
    check("R2 held high", word, snap);
    cs = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 falling edge", word, snap);

    // R8 serial mode off
    ser_mode_n = 1'b1;
    strobe(1'b1); strobe(1'b0);
    check("R8 frozen", word, snap);
    ser_mode_n = 1'b0;

    // R6 upper bits cleared on a 16-bit shift
    len = 1'b0; order = 1'b1;
    strobe(1'b1);
    check("R6 upper clear", word, {2'b00, snap[14:0], 1'b1});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule